// File: doc/BRIEF.md
# RSSI Conversion Sampling Controller

This block runs one received-signal-strength measurement at a time against an analog-to-digital converter. A start request raises a first converter-control strobe. A programmable number of cycles later it raises a second strobe. That second strobe stays high for a programmable number of cycles, or for one cycle per result bit in successive-approximation mode. Both strobes then drop together, and the 7-bit result is captured.

In external mode the result comes from a parallel converter bus. In successive-approximation mode the block walks a binary search over its own trial-code output and reads back a single comparator bit. The captured level is compared with a programmable lower limit, and a flag reports whether the level reaches that limit.

The settings live in two small register groups, each with its own write strobe:
- timing: the strobe spacing and the conversion hold time;
- control: the mode and the limit.

The sequencer takes a private copy of the timing and mode at the moment it accepts a start. Later writes therefore only affect the next measurement.

Top module: `rssi_sample_ctrl`

## Requirements
- R1: In reset, and afterwards until the first measurement completes, `strb_a_o`, `strb_b_o`, `done_o`, `rssi_valid_o` and `above_o` are 0, and `sar_code_o` and `rssi_o` are 0. The register reset values are delay 0, hold time 4'b1010, mode disabled and limit 0.
- R2: Mode encodings are 2'b01 external parallel converter and 2'b10 successive approximation. With mode 2'b00 or 2'b11, a start request is ignored and no strobe rises.
- R3: `strb_a_o` rises in the cycle after an accepted start. `strb_b_o` rises delay+1 cycles after `strb_a_o`. `strb_b_o` is only ever high while `strb_a_o` is high, and both fall on the same edge.
- R4: In external mode `strb_b_o` is high for hold+1 cycles. With the reset hold value 4'b1010 this is 11 cycles.
- R5: `rssi_o` is loaded on the edge on which `strb_b_o` falls. In external mode it takes the value of `adc_data_i` at that edge. `done_o` is high for exactly the following cycle, and `rssi_valid_o` then stays 1.
- R6: In successive-approximation mode, `strb_b_o` is high for 7 cycles whatever the hold value. `sar_code_o` presents trial codes most significant bit first, starting with 7'h40, and is 0 while `strb_b_o` is low. The result is the largest code for which `cmp_hi_i` (1 means input level >= trial code) was 1.
- R7: `above_o` is 1 exactly when `rssi_valid_o` is 1 and `rssi_o` >= limit, equality included. It follows a limit write in the next cycle.
- R8: A start request while a measurement is running is ignored. It neither alters the running strobes nor causes a second result.
- R9: Timing or mode writes made during a measurement do not affect that measurement; they take effect from the next accepted start.
- R10: Between capture edges, `rssi_o` holds its value regardless of `adc_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_we_i | input | 1 | Write strobe for delay and hold time |
| delay_i | input | 6 | Strobe spacing value (cycles minus one) |
| conv_time_i | input | 4 | Hold time value (cycles minus one) |
| ctrl_we_i | input | 1 | Write strobe for mode and limit |
| mode_i | input | 2 | Conversion mode |
| limit_i | input | 7 | Lower limit for the level compare |
| start_i | input | 1 | Measurement request |
| adc_data_i | input | 7 | Parallel converter result |
| cmp_hi_i | input | 1 | Comparator: analog level >= trial code |
| strb_a_o | output | 1 | First converter strobe |
| strb_b_o | output | 1 | Second converter strobe |
| sar_code_o | output | 7 | Trial code in successive-approximation mode |
| rssi_o | output | 7 | Captured signal level |
| rssi_valid_o | output | 1 | At least one level has been captured |
| above_o | output | 1 | Captured level reaches the limit |
| done_o | output | 1 | One-cycle pulse after a capture |

## Verification
On every cycle the assertions check several properties:
- the strobe nesting and the shared falling edge;
- that a request during a running measurement leaves it in its hold phase;
- the one-hot trial bit and the first trial code;
- the single-cycle done pulse, the sticky valid flag, and that the level register never moves outside a capture.

The exact spacing and hold counts cannot be seen by these properties, and neither can the reset hold value, the captured values, the binary-search result, the limit boundary or the deferred effect of writes during a run. Those are shown only by the bench's scenarios, which time every strobe and score every result against levels the bench itself chose.

// File: rtl/rssi_pkg.sv
// Shared types for the RSSI sampling controller.
package rssi_pkg;
    // Conversion mode encodings as seen on mode_i.
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_EXT = 2'b01,
        MODE_SAR = 2'b10,
        MODE_RSV = 2'b11
    } conv_mode_e;

    // Strobe sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_GAP  = 2'b01,
        ST_HOLD = 2'b10
    } seq_state_e;
endpackage

// File: rtl/rssi_cfg_regs.sv
// Settings registers for the RSSI controller.
// Two groups, each with its own write strobe: timing (spacing, hold) and
// control (mode, limit). Assumes writes are single-cycle strobes.
module rssi_cfg_regs
    import rssi_pkg::*;
#(
    parameter int DLY_W  = 6,
    parameter int CT_W   = 4,
    parameter int RSSI_W = 7,
    parameter logic [CT_W-1:0] CT_RST = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              timing_we_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic [CT_W-1:0]   conv_time_i,
    input  logic              ctrl_we_i,
    input  logic [1:0]        mode_i,
    input  logic [RSSI_W-1:0] limit_i,
    output logic [DLY_W-1:0]  delay_o,
    output logic [CT_W-1:0]   conv_time_o,
    output conv_mode_e        mode_o,
    output logic [RSSI_W-1:0] limit_o
);
    // Timing group: strobe spacing and hold time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_o     <= '0;
            conv_time_o <= CT_RST;
        end else if (timing_we_i) begin
            delay_o     <= delay_i;
            conv_time_o <= conv_time_i;
        end
    end

    // Control group: mode and lower limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= MODE_OFF;
            limit_o <= '0;
        end else if (ctrl_we_i) begin
            mode_o  <= conv_mode_e'(mode_i);
            limit_o <= limit_i;
        end
    end
endmodule

// File: rtl/rssi_strobe_seq.sv
// Two-strobe converter sequencer.
// Accepts a start only when idle and in an active mode. It snapshots mode and
// hold time, raises strobe A, waits delay+1 cycles, raises strobe B for
// hold+1 cycles (or RSSI_W cycles in SAR mode), then drops both strobes.
module rssi_strobe_seq
    import rssi_pkg::*;
#(
    parameter int DLY_W  = 6,
    parameter int CT_W   = 4,
    parameter int RSSI_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  conv_mode_e       mode_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [CT_W-1:0]  conv_time_i,
    output logic             strb_a_o,
    output logic             strb_b_o,
    output logic             sar_enter_o,
    output logic             sar_step_o,
    output logic             cap_en_o,
    output logic             cap_sar_o
);
    localparam int SAR_CW = $clog2(RSSI_W) + 1;
    localparam int CW_A   = (DLY_W > CT_W) ? DLY_W : CT_W;
    localparam int CNT_W  = (CW_A > SAR_CW) ? CW_A : SAR_CW;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sar_q;
    logic [CT_W-1:0]   ct_snap_q;
    logic              accept;
    logic              gap_end;
    logic              hold_end;

    // Start acceptance and phase-end decode.
    always_comb begin
        accept   = (state_q == ST_IDLE) && start_i &&
                   ((mode_i == MODE_EXT) || (mode_i == MODE_SAR));
        gap_end  = (state_q == ST_GAP)  && (cnt_q == '0);
        hold_end = (state_q == ST_HOLD) && (cnt_q == '0);
    end

    // Phase register, down-counter and per-measurement snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            sar_q     <= 1'b0;
            ct_snap_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q   <= ST_GAP;
                    cnt_q     <= CNT_W'(delay_i);
                    sar_q     <= (mode_i == MODE_SAR);
                    ct_snap_q <= conv_time_i;
                end
                ST_GAP: if (gap_end) begin
                    state_q <= ST_HOLD;
                    cnt_q   <= sar_q ? CNT_W'(RSSI_W - 1) : CNT_W'(ct_snap_q);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                ST_HOLD: if (hold_end) begin
                    state_q <= ST_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes and handshakes to the SAR engine and capture stage.
    always_comb begin
        strb_a_o    = (state_q != ST_IDLE);
        strb_b_o    = (state_q == ST_HOLD);
        sar_enter_o = gap_end && sar_q;
        sar_step_o  = (state_q == ST_HOLD) && sar_q;
        cap_en_o    = hold_end;
        cap_sar_o   = sar_q;
    end

    // R3: strobe B only inside strobe A
    p_b_inside_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strb_b_o |-> strb_a_o);
    // R3: strobe A falls only from the hold phase, with B
    p_fall_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_a_o) |-> $fell(strb_b_o));
    // R8: a request mid-hold does not end or restart the hold phase
    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cnt_q != '0 && start_i) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/rssi_sar_engine.sv
// Successive-approximation search over RSSI_W bits.
// On enter it clears the accumulator and sets the MSB trial bit. Each step
// keeps the trial bit when the comparator reports level >= trial, then moves
// to the next lower bit. Assumes exactly RSSI_W steps follow each enter.
module rssi_sar_engine #(
    parameter int RSSI_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              step_i,
    input  logic              cmp_hi_i,
    output logic [RSSI_W-1:0] code_o,
    output logic [RSSI_W-1:0] result_o
);
    localparam logic [RSSI_W-1:0] TOP_BIT = {1'b1, {(RSSI_W-1){1'b0}}};

    logic [RSSI_W-1:0] acc_q;
    logic [RSSI_W-1:0] bit_q;

    // Accumulator and trial-bit walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_q <= '0;
        end else if (enter_i) begin
            acc_q <= '0;
            bit_q <= TOP_BIT;
        end else if (step_i) begin
            if (cmp_hi_i) acc_q <= acc_q | bit_q;
            bit_q <= bit_q >> 1;
        end
    end

    // Trial code on the pins and the result seen at the final step.
    always_comb begin
        code_o   = step_i ? (acc_q | bit_q) : '0;
        result_o = acc_q | (cmp_hi_i ? bit_q : '0);
    end

    // R6: at most one trial bit active
    p_trial_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bit_q));
    // R6: first trial of a search is the MSB alone
    p_first_trial_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !$past(step_i)) |-> (code_o == TOP_BIT));
endmodule

// File: rtl/rssi_result_cmp.sv
// Result capture and lower-limit compare.
// Loads the level on the capture edge from the SAR engine or the parallel
// bus, pulses done for one cycle and reports level >= limit once valid.
module rssi_result_cmp #(
    parameter int RSSI_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic              cap_sar_i,
    input  logic [RSSI_W-1:0] ext_data_i,
    input  logic [RSSI_W-1:0] sar_result_i,
    input  logic [RSSI_W-1:0] limit_i,
    output logic [RSSI_W-1:0] rssi_o,
    output logic              valid_o,
    output logic              done_o,
    output logic              above_o
);
    // Level register, sticky valid and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rssi_o  <= '0;
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= cap_en_i;
            if (cap_en_i) begin
                rssi_o  <= cap_sar_i ? sar_result_i : ext_data_i;
                valid_o <= 1'b1;
            end
        end
    end

    // Threshold compare, inclusive of equality.
    always_comb above_o = valid_o && (rssi_o >= limit_i);

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5: valid stays set once a result exists
    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
    // R10: level only moves on a capture
    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rssi_o));
endmodule

// File: rtl/rssi_sample_ctrl.sv
// RSSI conversion sampling controller, top level.
// Ties the settings registers, strobe sequencer, SAR engine and result
// compare together. Assumes adc_data_i and cmp_hi_i are synchronous to clk.
module rssi_sample_ctrl
    import rssi_pkg::*;
#(
    parameter int DLY_W  = 6,
    parameter int CT_W   = 4,
    parameter int RSSI_W = 7,
    parameter logic [CT_W-1:0] CT_RST = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              timing_we_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic [CT_W-1:0]   conv_time_i,
    input  logic              ctrl_we_i,
    input  logic [1:0]        mode_i,
    input  logic [RSSI_W-1:0] limit_i,
    input  logic              start_i,
    input  logic [RSSI_W-1:0] adc_data_i,
    input  logic              cmp_hi_i,
    output logic              strb_a_o,
    output logic              strb_b_o,
    output logic [RSSI_W-1:0] sar_code_o,
    output logic [RSSI_W-1:0] rssi_o,
    output logic              rssi_valid_o,
    output logic              above_o,
    output logic              done_o
);
    logic [DLY_W-1:0]  delay_q;
    logic [CT_W-1:0]   ct_q;
    conv_mode_e        mode_q;
    logic [RSSI_W-1:0] limit_q;
    logic              sar_enter;
    logic              sar_step;
    logic              cap_en;
    logic              cap_sar;
    logic [RSSI_W-1:0] sar_result;

    rssi_cfg_regs #(
        .DLY_W(DLY_W), .CT_W(CT_W), .RSSI_W(RSSI_W), .CT_RST(CT_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .timing_we_i(timing_we_i), .delay_i(delay_i), .conv_time_i(conv_time_i),
        .ctrl_we_i(ctrl_we_i), .mode_i(mode_i), .limit_i(limit_i),
        .delay_o(delay_q), .conv_time_o(ct_q), .mode_o(mode_q), .limit_o(limit_q)
    );

    rssi_strobe_seq #(
        .DLY_W(DLY_W), .CT_W(CT_W), .RSSI_W(RSSI_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_q),
        .delay_i(delay_q), .conv_time_i(ct_q),
        .strb_a_o(strb_a_o), .strb_b_o(strb_b_o),
        .sar_enter_o(sar_enter), .sar_step_o(sar_step),
        .cap_en_o(cap_en), .cap_sar_o(cap_sar)
    );

    rssi_sar_engine #(.RSSI_W(RSSI_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .enter_i(sar_enter), .step_i(sar_step),
        .cmp_hi_i(cmp_hi_i), .code_o(sar_code_o), .result_o(sar_result)
    );

    rssi_result_cmp #(.RSSI_W(RSSI_W)) u_res (
        .clk(clk), .rst_n(rst_n), .cap_en_i(cap_en), .cap_sar_i(cap_sar),
        .ext_data_i(adc_data_i), .sar_result_i(sar_result), .limit_i(limit_q),
        .rssi_o(rssi_o), .valid_o(rssi_valid_o), .done_o(done_o), .above_o(above_o)
    );
endmodule

// File: tb/rssi_sample_ctrl_bench.sv
`timescale 1ns/1ps
module rssi_sample_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       timing_we = 1'b0;
    logic [5:0] delay = '0;
    logic [3:0] conv_time = '0;
    logic       ctrl_we = 1'b0;
    logic [1:0] mode = '0;
    logic [6:0] limit = '0;
    logic       start = 1'b0;
    logic [6:0] adc_data = '0;
    logic       cmp_hi;
    logic       strb_a, strb_b, rssi_valid, above, done;
    logic [6:0] sar_code, rssi;
    logic [6:0] analog_lvl = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    logic [6:0] cur_limit = '0;

    always #4 clk = ~clk;

    // Comparator model: level at or above the trial code.
    assign cmp_hi = (sar_code <= analog_lvl);

    rssi_sample_ctrl u_rssi_sample_ctrl (
        .clk(clk), .rst_n(rst_n), .timing_we_i(timing_we), .delay_i(delay),
        .conv_time_i(conv_time), .ctrl_we_i(ctrl_we), .mode_i(mode),
        .limit_i(limit), .start_i(start), .adc_data_i(adc_data),
        .cmp_hi_i(cmp_hi), .strb_a_o(strb_a), .strb_b_o(strb_b),
        .sar_code_o(sar_code), .rssi_o(rssi), .rssi_valid_o(rssi_valid),
        .above_o(above), .done_o(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_timing(input logic [5:0] d, input logic [3:0] ct);
        @(negedge clk); timing_we = 1'b1; delay = d; conv_time = ct;
        @(negedge clk); timing_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [1:0] m, input logic [6:0] l);
        @(negedge clk); ctrl_we = 1'b1; mode = m; limit = l; cur_limit = l;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    // Driver: queue the expected result, run one measurement, time the strobes.
    task automatic run_conv(input int exp_gap, input int exp_w, input logic [6:0] exp_val,
                            input bit is_sar, input bit poke_start, input bit poke_cfg);
        int gap = 0;
        int w = 0;
        exp_q.push_back({(exp_val >= cur_limit), exp_val});
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(strb_a === 1'b1, "R3 strobe A after start", strb_a, 1);
        while (strb_a && !strb_b && gap < 200) begin
            gap++;
            if (poke_cfg && gap == 1) begin
                timing_we = 1'b1; delay = 6'd0; conv_time = 4'd1;
            end else timing_we = 1'b0;
            @(negedge clk);
        end
        timing_we = 1'b0;
        chk(gap == exp_gap, poke_cfg ? "R9 spacing kept" : "R3 spacing", gap, exp_gap);
        if (is_sar) chk(sar_code == 7'h40, "R6 first trial", sar_code, 64);
        while (strb_b && w < 200) begin
            if (!strb_a) chk(0, "R3 B without A", 0, 1);
            w++;
            start = (poke_start && w == 1);
            @(negedge clk);
        end
        start = 1'b0;
        chk(w == exp_w, is_sar ? "R6 SAR hold" : (poke_cfg ? "R9 hold kept" : "R4 hold"), w, exp_w);
        chk(strb_a == 1'b0, "R3 fall together", strb_a, 0);
        if (is_sar) chk(sar_code == '0, "R6 code idle", sar_code, 0);
        repeat (4) @(negedge clk);
        if (poke_start) chk(strb_a == 1'b0, "R8 no restart", strb_a, 0);
    endtask

    // Monitor: score each done pulse against the queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) chk(0, "R8 unexpected result", rssi, -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rssi == e[6:0], "R5/R6 level", rssi, e[6:0]);
                chk(above == e[7], "R7 flag at result", above, e[7]);
                chk(rssi_valid == 1'b1, "R5 valid", rssi_valid, 1);
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(strb_a == 0 && strb_b == 0 && done == 0, "R1 strobes in reset", strb_a, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rssi == 0 && sar_code == 0, "R1 level zero", rssi, 0);
        chk(rssi_valid == 0 && above == 0, "R1 flags zero", above, 0);

        // R2 disabled modes ignore start
        for (int m = 0; m < 2; m++) begin
            if (m == 1) wr_ctrl(2'b11, 7'd0);
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            for (int i = 0; i < 4; i++) begin
                chk(strb_a == 0, "R2 disabled mode", strb_a, 0);
                @(negedge clk);
            end
        end

        // R4 reset hold value 1010 -> 11 cycles, spacing 1
        wr_ctrl(2'b01, 7'd20);
        adc_data = 7'd35;
        run_conv(1, 11, 7'd35, 0, 0, 0);

        // R7 equality counts as reaching the limit
        wr_timing(6'd5, 4'd3);
        adc_data = 7'd20;
        run_conv(6, 4, 7'd20, 0, 0, 0);
        wr_ctrl(2'b01, 7'd21);
        chk(above == 0, "R7 limit one above", above, 0);
        wr_ctrl(2'b01, 7'd20);
        chk(above == 1, "R7 limit equal", above, 1);

        // R8 start during hold is ignored
        wr_timing(6'd2, 4'd6);
        adc_data = 7'd100;
        run_conv(3, 7, 7'd100, 0, 1, 0);

        // R9 write during a run is deferred
        adc_data = 7'd9;
        run_conv(3, 7, 7'd9, 0, 0, 1);
        adc_data = 7'd64;
        run_conv(1, 2, 7'd64, 0, 0, 0);

        // R6 successive approximation, hold value ignored
        wr_ctrl(2'b10, 7'd50);
        adc_data = 7'd5;
        analog_lvl = 7'd93;
        run_conv(1, 7, 7'd93, 1, 0, 0);
        analog_lvl = 7'd0;
        run_conv(1, 7, 7'd0, 1, 0, 0);
        analog_lvl = 7'd127;
        run_conv(1, 7, 7'd127, 1, 0, 0);

        // R3 largest spacing, shortest hold
        wr_ctrl(2'b01, 7'd50);
        wr_timing(6'd63, 4'd0);
        adc_data = 7'd50;
        run_conv(64, 1, 7'd50, 0, 0, 0);

        // R10 bus changes outside capture are ignored
        adc_data = 7'd3;
        repeat (5) @(negedge clk);
        chk(rssi == 7'd50, "R10 level held", rssi, 50);
        chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
        summary();
    end
endmodule